// File: doc/BRIEF.md
# Binary Shift, Parity-Jump and Bitwise Unit

This block adds bit-level operations to a sign-magnitude register pair. Each register, here called the accumulator and the extension, holds a sign and a magnitude of five 8-bit bytes. The caller presents the current register values, an operation class, a function code, a count or target value and a second operand. It then pulses `start`. One cycle later the block returns the updated register values, a jump decision and a one-cycle `done` strobe.

There are three kinds of work. A binary shift moves the 80-bit concatenation {accumulator magnitude, extension magnitude} left or right by a bit count, and both signs stay as they were. A parity jump inspects the least significant bit of one register and reports whether to branch. A bitwise operation combines the accumulator with the operand, and the sign takes part as one extra bit above the magnitude.

Control is a two-state machine. `ST_IDLE` waits. The transition *accept* (start seen in `ST_IDLE`) moves to `ST_DONE`. `ST_DONE` presents the result for one cycle. From there, *again* (start seen in `ST_DONE`) stays in `ST_DONE` with a new result, and *retire* (no start) returns to `ST_IDLE`.

Top module: `bitop_unit`

## Requirements
- R1: The class codes are 0 = shift, 1 = accumulator jump, 2 = extension jump and 3 = bitwise. Under class 0, function 6 shifts the 80-bit value {ra_mag, rx_mag} left by `m_val` places. Bits leaving the extension enter the accumulator's bit 0, bits leaving the top are lost, and zeros fill from the right.
- R2: Under class 0, function 7 shifts {ra_mag, rx_mag} right by `m_val` places. Bits leaving the accumulator's bit 0 enter the extension's bit 39, and zeros fill from the left.
- R3: A binary shift returns both signs unchanged.
- R4: A shift count of 80 or larger, up to the full 12-bit range, returns zero in both magnitudes.
- R5: Under class 1, function 6 sets `jump_taken` when bit 0 of ra_mag is 0, and function 7 sets it when that bit is 1.
- R6: Under class 2, functions 6 and 7 make the same even/odd test on bit 0 of rx_mag.
- R7: A jump operation returns all four register values unchanged. `jump_taken` is never set for any class other than 1 or 2.
- R8: Under class 3, function 9 inverts all 41 bits {sign, magnitude} of the accumulator. The sign bit is 1 for negative and 0 for positive.
- R9: Under class 3, functions 10, 11 and 12 write {ra_sign, ra_mag} AND, OR and XOR {v_sign, v_mag} into the accumulator, with the sign encoded as a bit in the same way. The extension is left unchanged.
- R10: Any function code not listed for the class returns all registers unchanged. It sets `illegal` and clears `jump_taken`.
- R11: `done` is high in exactly the cycle after each cycle with `start` high, and is low otherwise. `jump_taken` and `illegal` are valid only while `done` is high and are low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation on the presented values |
| op_class | input | 2 | Operation class code |
| fsel | input | 8 | Function code within the class |
| m_val | input | 12 | Shift count (jump target not used here) |
| v_sign | input | 1 | Operand sign, 1 = negative |
| v_mag | input | 40 | Operand magnitude |
| ra_sign | input | 1 | Current accumulator sign |
| ra_mag | input | 40 | Current accumulator magnitude |
| rx_sign | input | 1 | Current extension sign |
| rx_mag | input | 40 | Current extension magnitude |
| ra_sign_o | output | 1 | Updated accumulator sign |
| ra_mag_o | output | 40 | Updated accumulator magnitude |
| rx_sign_o | output | 1 | Updated extension sign |
| rx_mag_o | output | 40 | Updated extension magnitude |
| jump_taken | output | 1 | Parity jump condition met |
| illegal | output | 1 | Unlisted function code |
| done | output | 1 | Result valid strobe |

## Verification
The hardest cases to reach are the shift boundaries. These are the bits that cross the junction between the two registers, counts of exactly 79 and 80, and counts whose upper bits alone are set (such as 128 or 4095). Only these cases exercise the overflow clearing apart from the barrel stages. The stimulus sweeps every count from 0 to 84 in both directions, plus a set of large counts, over several magnitude patterns. The patterns include single junction bits and all ones. Every function code is also swept in every class, which makes sure that each unlisted code reaches the illegal path.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    typedef enum logic [1:0] {
        CLS_SHIFT   = 2'd0,
        CLS_JMPA    = 2'd1,
        CLS_JMPX    = 2'd2,
        CLS_SPECIAL = 2'd3
    } op_class_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } state_e;

    localparam int FN_SHL  = 6;
    localparam int FN_SHR  = 7;
    localparam int FN_EVEN = 6;
    localparam int FN_ODD  = 7;
    localparam int FN_NOT  = 9;
    localparam int FN_AND  = 10;
    localparam int FN_OR   = 11;
    localparam int FN_XOR  = 12;

    typedef enum logic [1:0] {
        LG_NOT = 2'd0,
        LG_AND = 2'd1,
        LG_OR  = 2'd2,
        LG_XOR = 2'd3
    } logic_op_e;

endpackage

// File: rtl/bitop_shifter.sv
module bitop_shifter #(
    parameter int W    = 80,
    parameter int CW   = 12
) (
    input  logic [W-1:0]  din,
    input  logic [CW-1:0] cnt,
    input  logic          dir_right,
    output logic [W-1:0]  dout
);
    localparam int SW = (CW < $clog2(W)) ? CW : $clog2(W);
    localparam logic [CW:0] LIMIT = (CW+1)'(W);

    logic [W-1:0] stg [0:SW];
    logic         too_far;

    assign stg[0]  = din;
    assign too_far = ({1'b0, cnt} >= LIMIT);

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int AMT = 2 ** k;
        logic [W-1:0] moved;
        assign moved      = dir_right ? (stg[k] >> AMT) : (stg[k] << AMT);
        assign stg[k + 1] = cnt[k] ? moved : stg[k];
    end

    assign dout = too_far ? '0 : stg[SW];
endmodule

// File: rtl/bitop_parity.sv
module bitop_parity #(
    parameter int W = 40
) (
    input  logic [W-1:0] mag,
    input  logic         want_odd,
    output logic         hit
);
    logic low_bit;
    assign low_bit = mag[0];
    assign hit     = want_odd ? low_bit : ~low_bit;
endmodule

// File: rtl/bitop_logic.sv
module bitop_logic
    import bitop_pkg::*;
#(
    parameter int W = 41
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_op_e    sel,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (sel)
            LG_NOT:  y = ~a;
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 5,
    parameter int CNT_W  = 12,
    parameter int F_W    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [1:0]               op_class,
    input  logic [F_W-1:0]           fsel,
    input  logic [CNT_W-1:0]         m_val,
    input  logic                     v_sign,
    input  logic [BYTE_W*NBYTES-1:0] v_mag,
    input  logic                     ra_sign,
    input  logic [BYTE_W*NBYTES-1:0] ra_mag,
    input  logic                     rx_sign,
    input  logic [BYTE_W*NBYTES-1:0] rx_mag,
    output logic                     ra_sign_o,
    output logic [BYTE_W*NBYTES-1:0] ra_mag_o,
    output logic                     rx_sign_o,
    output logic [BYTE_W*NBYTES-1:0] rx_mag_o,
    output logic                     jump_taken,
    output logic                     illegal,
    output logic                     done
);
    localparam int MAG_W  = BYTE_W * NBYTES;
    localparam int PAIR_W = 2 * MAG_W;
    localparam int WORD_W = MAG_W + 1;

    op_class_e cls;
    assign cls = op_class_e'(op_class);

    // shared datapath pieces
    logic [PAIR_W-1:0] sh_out;
    logic              par_a_hit, par_x_hit;
    logic [WORD_W-1:0] lg_out;
    logic_op_e         lg_sel;

    bitop_shifter #(.W(PAIR_W), .CW(CNT_W)) u_shift (
        .din       ({ra_mag, rx_mag}),
        .cnt       (m_val),
        .dir_right (fsel == F_W'(FN_SHR)),
        .dout      (sh_out)
    );

    bitop_parity #(.W(MAG_W)) u_par_a (
        .mag      (ra_mag),
        .want_odd (fsel == F_W'(FN_ODD)),
        .hit      (par_a_hit)
    );

    bitop_parity #(.W(MAG_W)) u_par_x (
        .mag      (rx_mag),
        .want_odd (fsel == F_W'(FN_ODD)),
        .hit      (par_x_hit)
    );

    always_comb begin
        unique case (fsel)
            F_W'(FN_AND): lg_sel = LG_AND;
            F_W'(FN_OR):  lg_sel = LG_OR;
            F_W'(FN_XOR): lg_sel = LG_XOR;
            default:      lg_sel = LG_NOT;
        endcase
    end

    bitop_logic #(.W(WORD_W)) u_logic (
        .a   ({ra_sign, ra_mag}),
        .b   ({v_sign, v_mag}),
        .sel (lg_sel),
        .y   (lg_out)
    );

    // next-result decode
    logic             n_ra_s, n_rx_s, n_jmp, n_ill;
    logic [MAG_W-1:0] n_ra_m, n_rx_m;
    logic             f_pair, f_logic;

    assign f_pair  = (fsel == F_W'(6)) || (fsel == F_W'(7));
    assign f_logic = (fsel >= F_W'(FN_NOT)) && (fsel <= F_W'(FN_XOR));

    always_comb begin
        n_ra_s = ra_sign;
        n_ra_m = ra_mag;
        n_rx_s = rx_sign;
        n_rx_m = rx_mag;
        n_jmp  = 1'b0;
        n_ill  = 1'b0;
        unique case (cls)
            CLS_SHIFT: begin
                if (f_pair) begin
                    n_ra_m = sh_out[PAIR_W-1:MAG_W];
                    n_rx_m = sh_out[MAG_W-1:0];
                end else begin
                    n_ill = 1'b1;
                end
            end
            CLS_JMPA: begin
                if (f_pair) n_jmp = par_a_hit;
                else        n_ill = 1'b1;
            end
            CLS_JMPX: begin
                if (f_pair) n_jmp = par_x_hit;
                else        n_ill = 1'b1;
            end
            CLS_SPECIAL: begin
                if (f_logic) {n_ra_s, n_ra_m} = lg_out;
                else         n_ill = 1'b1;
            end
            default: n_ill = 1'b1;
        endcase
    end

    // state register
    state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_DONE;
            ST_DONE: state_d = start ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers
    logic jmp_q, ill_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ra_sign_o <= 1'b0;
            ra_mag_o  <= '0;
            rx_sign_o <= 1'b0;
            rx_mag_o  <= '0;
            jmp_q     <= 1'b0;
            ill_q     <= 1'b0;
        end else if (start) begin
            ra_sign_o <= n_ra_s;
            ra_mag_o  <= n_ra_m;
            rx_sign_o <= n_rx_s;
            rx_mag_o  <= n_rx_m;
            jmp_q     <= n_jmp;
            ill_q     <= n_ill;
        end
    end

    assign done       = (state_q == ST_DONE);
    assign jump_taken = done & jmp_q;
    assign illegal    = done & ill_q;
endmodule

// File: rtl/bitop_chk.sv
module bitop_chk #(
    parameter int MAG_W = 40,
    parameter int CNT_W = 12,
    parameter int F_W   = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [1:0]       op_class,
    input logic [F_W-1:0]   fsel,
    input logic [CNT_W-1:0] m_val,
    input logic             ra_sign,
    input logic [MAG_W-1:0] ra_mag,
    input logic             rx_sign,
    input logic [MAG_W-1:0] rx_mag,
    input logic             ra_sign_o,
    input logic [MAG_W-1:0] ra_mag_o,
    input logic             rx_sign_o,
    input logic [MAG_W-1:0] rx_mag_o,
    input logic             jump_taken,
    input logic             illegal,
    input logic             done
);
    // R11
    start_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    // R11
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(start));

    // R3
    shift_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && op_class == 2'd0 && (fsel == F_W'(6) || fsel == F_W'(7))
        |=> ra_sign_o == $past(ra_sign) && rx_sign_o == $past(rx_sign));

    // R4
    big_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && op_class == 2'd0 && (fsel == F_W'(6) || fsel == F_W'(7))
        && m_val >= CNT_W'(2 * MAG_W)
        |=> ra_mag_o == '0 && rx_mag_o == '0);

    // R7
    jump_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && (op_class == 2'd0 || op_class == 2'd3) |=> !jump_taken);

    // R10
    illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start ##1 illegal |-> ra_mag_o == $past(ra_mag) && rx_mag_o == $past(rx_mag)
        && ra_sign_o == $past(ra_sign) && rx_sign_o == $past(rx_sign) && !jump_taken);
endmodule

bind bitop_unit bitop_chk #(.MAG_W(MAG_W), .CNT_W(CNT_W), .F_W(F_W)) u_chk (.*);

// File: tb/tb_bitop_unit.sv
module tb_bitop_unit;
    localparam int MW = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    op_class = '0;
    logic [7:0]    fsel = '0;
    logic [11:0]   m_val = '0;
    logic          v_sign = 1'b0;
    logic [MW-1:0] v_mag = '0;
    logic          ra_sign = 1'b0;
    logic [MW-1:0] ra_mag = '0;
    logic          rx_sign = 1'b0;
    logic [MW-1:0] rx_mag = '0;
    logic          ra_sign_o, rx_sign_o, jump_taken, illegal, done;
    logic [MW-1:0] ra_mag_o, rx_mag_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    bitop_unit dut (.*);

    task automatic check(input string req, input logic [84:0] act, input logic [84:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h (cls=%0d f=%0d m=%0d)",
                     req, act, exp, op_class, fsel, m_val);
        end
    endtask

    function automatic logic [84:0] pack(input logic d, input logic j, input logic il,
                                         input logic as, input logic [MW-1:0] am,
                                         input logic xs, input logic [MW-1:0] xm);
        return {d, j, il, as, am, xs, xm};
    endfunction

    logic [63:0] seed = 64'h9E3779B97F4A7C15;
    function automatic logic [MW-1:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 7);
        seed = seed ^ (seed << 17);
        return seed[MW-1:0];
    endfunction

    // one operation: drive, wait one edge, return observed tuple
    task automatic run(input logic [1:0] c, input logic [7:0] f, input logic [11:0] m,
                       output logic [84:0] got);
        @(negedge clk);
        op_class = c; fsel = f; m_val = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got = pack(done, jump_taken, illegal, ra_sign_o, ra_mag_o, rx_sign_o, rx_mag_o);
    endtask

    function automatic logic [84:0] same_regs(input logic j, input logic il);
        return pack(1'b1, j, il, ra_sign, ra_mag, rx_sign, rx_mag);
    endfunction

    initial begin
        #(20 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [84:0] got, exp;
        logic [79:0] pair, res;
        logic [40:0] a, b, y;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 reset", {82'd0, done, jump_taken, illegal}, 85'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 idle", {82'd0, done, jump_taken, illegal}, 85'd0);

        // shifts: R1 R2 R3 R4
        for (int pat = 0; pat < 5; pat++) begin
            for (int dir = 0; dir < 2; dir++) begin
                for (int mi = 0; mi < 90; mi++) begin
                    int m;
                    m = (mi <= 84) ? mi : (mi == 85 ? 127 : mi == 86 ? 128 :
                                           mi == 87 ? 255 : mi == 88 ? 2048 : 4095);
                    case (pat)
                        0: begin ra_mag = '0; rx_mag = 40'h80_0000_0000; end
                        1: begin ra_mag = 40'h1; rx_mag = '0; end
                        2: begin ra_mag = '1; rx_mag = '1; end
                        default: begin ra_mag = rnd(); rx_mag = rnd(); end
                    endcase
                    ra_sign = pat[0]; rx_sign = ~mi[0];
                    pair = {ra_mag, rx_mag};
                    res = (m >= 80) ? 80'd0 : (dir == 0 ? pair << m : pair >> m);
                    exp = pack(1'b1, 1'b0, 1'b0, ra_sign, res[79:40], rx_sign, res[39:0]);
                    run(2'd0, dir == 0 ? 8'd6 : 8'd7, 12'(m), got);
                    if (m >= 80) check("R4 wide count clears", got, exp);
                    else if (dir == 0) check("R1 left shift / R3 signs", got, exp);
                    else check("R2 right shift / R3 signs", got, exp);
                end
            end
        end

        // jumps: R5 R6 R7
        for (int i = 0; i < 24; i++) begin
            for (int c = 1; c <= 2; c++) begin
                for (int f = 6; f <= 7; f++) begin
                    logic bit0;
                    ra_mag = rnd(); rx_mag = rnd(); ra_sign = i[0]; rx_sign = i[1];
                    m_val = 12'(i);
                    bit0 = (c == 1) ? ra_mag[0] : rx_mag[0];
                    exp = same_regs((f == 7) ? bit0 : ~bit0, 1'b0);
                    run(2'(c), 8'(f), 12'(i * 37), got);
                    if (c == 1) check("R5 acc parity jump / R7", got, exp);
                    else check("R6 ext parity jump / R7", got, exp);
                end
            end
        end

        // bitwise: R8 R9
        for (int i = 0; i < 32; i++) begin
            for (int f = 9; f <= 12; f++) begin
                ra_mag = (i == 0) ? '0 : (i == 1) ? '1 : rnd();
                v_mag = rnd(); rx_mag = rnd();
                ra_sign = i[0]; v_sign = i[1]; rx_sign = i[2];
                a = {ra_sign, ra_mag}; b = {v_sign, v_mag};
                case (f)
                    9: y = ~a;
                    10: y = a & b;
                    11: y = a | b;
                    default: y = a ^ b;
                endcase
                exp = pack(1'b1, 1'b0, 1'b0, y[40], y[39:0], rx_sign, rx_mag);
                run(2'd3, 8'(f), 12'd5, got);
                if (f == 9) check("R8 not with sign bit", got, exp);
                else check("R9 and/or/xor with sign bit", got, exp);
            end
        end

        // illegal codes: R10, and done single pulse R11
        for (int c = 0; c < 4; c++) begin
            for (int f = 0; f < 256; f++) begin
                bit legal;
                legal = (c == 3) ? (f >= 9 && f <= 12) : (f == 6 || f == 7);
                if (!legal) begin
                    ra_mag = rnd(); rx_mag = rnd(); ra_sign = f[0]; rx_sign = f[1];
                    v_mag = rnd(); v_sign = f[2];
                    run(2'(c), 8'(f), 12'd3, got);
                    check("R10 unlisted code", got, same_regs(1'b0, 1'b1));
                    if (f % 64 == 0) begin
                        @(negedge clk);
                        check("R11 done low after pulse",
                              {82'd0, done, jump_taken, illegal}, 85'd0);
                    end
                end
            end
        end

        // back-to-back starts: R11
        ra_mag = 40'h3; rx_mag = 40'h0; ra_sign = 0; rx_sign = 0;
        @(negedge clk);
        op_class = 2'd1; fsel = 8'd7; start = 1'b1;
        @(negedge clk);
        check("R11 first of pair", {82'd0, done, jump_taken, illegal}, {82'd0, 3'b110});
        fsel = 8'd6;
        @(negedge clk);
        start = 1'b0;
        check("R11 second of pair", {82'd0, done, jump_taken, illegal}, {82'd0, 3'b100});
        @(negedge clk);
        check("R11 retire", {82'd0, done, jump_taken, illegal}, 85'd0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule